// File: doc/BRIEF.md
# MLT-3 Line Codec with Loopback

This block is the digital datapath of a twisted-pair transceiver. One bit is taken per clock. On the transmit side a serial binary stream becomes a three-level line symbol coded in two bits. On the receive side a three-level symbol stream is turned back into one binary bit per clock. A coding input chooses either MLT-3 or plain two-level binary, and the choice applies to both directions at once. A loopback input sends transmit bits straight to the receive output. A cable-fault input parks the receive output at a static level.

The transmit encoder is a four-state machine: `ST_ZERO_UP` (level 0, next step toward +1), `ST_POS` (+1), `ST_ZERO_DN` (level 0, next step toward -1) and `ST_NEG` (-1). A 1 bit under MLT-3 coding takes the transition to the following state in the ring ZERO_UP→POS→ZERO_DN→NEG→ZERO_UP. A 0 bit keeps the state. Whenever binary coding is in force the state holds. The receive side picks one of four sources: `SRC_LINE_MLT3` (a change of level gives 1), `SRC_LINE_BIN` (+1 gives 1), `SRC_LOOP` (the transmit bit) or `SRC_PARKED` (a fixed level). The source is chosen with loopback first, then cable fault, then the coding input. Line codes are 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1.

Top module: `mlt3_line_codec`

## Requirements
- R1: A synchronous reset sets line_tx to 2'b00 and rx_bit to 0. It puts the encoder in ST_ZERO_UP, so the first MLT-3 1 bit after reset gives +1 (2'b01). It also clears the previous received level to 0.
- R2: With enc_binary=0 and loop_en=0, a 1 on tx_bit moves line_tx one step along the cycle 0, +1, 0, -1. A 0 holds the current level. line_tx changes one clock after tx_bit is sampled.
- R3: With enc_binary=1, line_tx is +1 (2'b01) for a 1 and -1 (2'b11) for a 0, one clock after sampling.
- R4: With enc_binary=0, loop_en=0 and cable_fault=0, rx_bit is 1 one clock after a line_rx level that differs from the level received in the cycle before, and 0 otherwise.
- R5: With enc_binary=1, loop_en=0 and cable_fault=0, rx_bit is 1 one clock after line_rx is +1, and 0 after 0 or -1.
- R6: line_tx never carries 2'b10. A received 2'b10 is taken as level 0, both for decoding and as the previous level.
- R7: With loop_en=1, rx_bit equals tx_bit one clock later and line_rx has no effect on rx_bit.
- R8: With loop_en=1, line_tx still carries tx_bit in binary coding (+1/-1) whatever enc_binary is.
- R9: With cable_fault=1 and loop_en=0, rx_bit is held at 0 one clock later. With loop_en=1 the fault has no effect.
- R10: A change of coding or loopback takes effect at the next clock edge. The encoder state holds while binary coding drives the line, and MLT-3 coding resumes from that held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_bit | input | 1 | Serial transmit data |
| enc_binary | input | 1 | 0 = MLT-3 coding, 1 = two-level binary coding |
| loop_en | input | 1 | Loopback: transmit data goes to rx_bit |
| cable_fault | input | 1 | Active-high fault: parks rx_bit unless looping back |
| line_rx | input | 2 | Received line symbol (01=+1, 00=0, 11=-1, 10 read as 0) |
| line_tx | output | 2 | Transmitted line symbol (01=+1, 00=0, 11=-1) |
| rx_bit | output | 1 | Recovered receive data |

## Verification
The assertions assume that every input has a defined 0/1 value at each rising edge, including the cycles in reset. They also assume that a property's window only looks back into clocks where the mode inputs were sampled, because they compare rx_bit and line_tx against inputs from the previous edge. The bench drives all inputs from time zero and changes them only on falling edges. Its stimulus includes the unused 2'b10 receive code, since the design must absorb that code rather than rely on it never arriving.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;

    localparam int SYM_W = 2;

    localparam logic [SYM_W-1:0] SYM_ZERO = 2'b00;
    localparam logic [SYM_W-1:0] SYM_POS  = 2'b01;
    localparam logic [SYM_W-1:0] SYM_NEG  = 2'b11;
    localparam logic [SYM_W-1:0] SYM_BAD  = 2'b10;

    typedef enum logic [1:0] {
        ST_ZERO_UP = 2'd0,
        ST_POS     = 2'd1,
        ST_ZERO_DN = 2'd2,
        ST_NEG     = 2'd3
    } enc_state_t;

    typedef enum logic [1:0] {
        SRC_LINE_MLT3 = 2'd0,
        SRC_LINE_BIN  = 2'd1,
        SRC_LOOP      = 2'd2,
        SRC_PARKED    = 2'd3
    } rx_src_t;

    function automatic logic [SYM_W-1:0] sym_of_state(input enc_state_t s);
        logic [SYM_W-1:0] r;
        unique case (s)
            ST_POS:  r = SYM_POS;
            ST_NEG:  r = SYM_NEG;
            default: r = SYM_ZERO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mlt3_mode_ctrl.sv
module mlt3_mode_ctrl
    import mlt3_pkg::*;
(
    input  logic    enc_binary,
    input  logic    loop_en,
    input  logic    cable_fault,
    output logic    tx_binary,
    output rx_src_t rx_src
);

    // Loopback forces binary coding on the line.
    always_comb begin
        tx_binary = enc_binary | loop_en;
    end

    // Receive source priority: loopback, then fault, then coding.
    always_comb begin
        if (loop_en) begin
            rx_src = SRC_LOOP;
        end else if (cable_fault) begin
            rx_src = SRC_PARKED;
        end else if (enc_binary) begin
            rx_src = SRC_LINE_BIN;
        end else begin
            rx_src = SRC_LINE_MLT3;
        end
    end

endmodule

// File: rtl/mlt3_tx_enc.sv
module mlt3_tx_enc
    import mlt3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_bit,
    input  logic             use_bin,
    output logic [SYM_W-1:0] line_tx
);

    enc_state_t       state_q;
    enc_state_t       state_d;
    logic [SYM_W-1:0] sym_d;
    logic [SYM_W-1:0] sym_q;

    // Next-state logic: a 1 under MLT-3 coding steps around the ring.
    always_comb begin
        state_d = state_q;
        if (!use_bin && tx_bit) begin
            unique case (state_q)
                ST_ZERO_UP: state_d = ST_POS;
                ST_POS:     state_d = ST_ZERO_DN;
                ST_ZERO_DN: state_d = ST_NEG;
                ST_NEG:     state_d = ST_ZERO_UP;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ZERO_UP;
        end else begin
            state_q <= state_d;
        end
    end

    // Output symbol.
    always_comb begin
        if (use_bin) begin
            sym_d = tx_bit ? SYM_POS : SYM_NEG;
        end else begin
            sym_d = sym_of_state(state_d);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= SYM_ZERO;
        end else begin
            sym_q <= sym_d;
        end
    end

    assign line_tx = sym_q;

    assert_zero_bit_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!use_bin && !tx_bit) |=> $stable(state_q));

    assert_step_leaves_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!use_bin && tx_bit && (state_q == ST_ZERO_UP || state_q == ST_ZERO_DN))
        |=> (line_tx != SYM_ZERO));

    assert_binary_level_R3: assert property (@(posedge clk) disable iff (rst)
        use_bin |=> (line_tx == ($past(tx_bit) ? SYM_POS : SYM_NEG)));

    assert_no_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
        line_tx != SYM_BAD);

    assert_state_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        use_bin |=> $stable(state_q));

endmodule

// File: rtl/mlt3_rx_dec.sv
module mlt3_rx_dec
    import mlt3_pkg::*;
#(
    parameter logic PARK_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] line_rx,
    input  logic             loop_bit,
    input  rx_src_t          src,
    output logic             rx_bit
);

    logic [SYM_W-1:0] lvl_now;
    logic [SYM_W-1:0] prev_q;
    logic             bit_d;
    logic             bit_q;

    // The unused code reads as level 0.
    always_comb begin
        lvl_now = (line_rx == SYM_BAD) ? SYM_ZERO : line_rx;
    end

    always_comb begin
        unique case (src)
            SRC_LINE_MLT3: bit_d = (lvl_now != prev_q);
            SRC_LINE_BIN:  bit_d = (lvl_now == SYM_POS);
            SRC_LOOP:      bit_d = loop_bit;
            SRC_PARKED:    bit_d = PARK_LEVEL;
        endcase
    end

    // The previous level tracks the line in every mode.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= SYM_ZERO;
            bit_q  <= 1'b0;
        end else begin
            prev_q <= lvl_now;
            bit_q  <= bit_d;
        end
    end

    assign rx_bit = bit_q;

    assert_loop_echo_R7: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_LOOP) |=> (rx_bit == $past(loop_bit)));

    assert_parked_R9: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PARKED) |=> (rx_bit == PARK_LEVEL));

    assert_bin_rx_R5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_LINE_BIN && line_rx != SYM_POS) |=> !rx_bit);

endmodule

// File: rtl/mlt3_line_codec.sv
module mlt3_line_codec
    import mlt3_pkg::*;
#(
    parameter logic PARK_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_bit,
    input  logic             enc_binary,
    input  logic             loop_en,
    input  logic             cable_fault,
    input  logic [SYM_W-1:0] line_rx,
    output logic [SYM_W-1:0] line_tx,
    output logic             rx_bit
);

    logic    tx_binary;
    rx_src_t rx_src;

    mlt3_mode_ctrl u_mode (
        .enc_binary  (enc_binary),
        .loop_en     (loop_en),
        .cable_fault (cable_fault),
        .tx_binary   (tx_binary),
        .rx_src      (rx_src)
    );

    mlt3_tx_enc u_tx (
        .clk     (clk),
        .rst     (rst),
        .tx_bit  (tx_bit),
        .use_bin (tx_binary),
        .line_tx (line_tx)
    );

    mlt3_rx_dec #(
        .PARK_LEVEL (PARK_LEVEL)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .line_rx  (line_rx),
        .loop_bit (tx_bit),
        .src      (rx_src),
        .rx_bit   (rx_bit)
    );

    assert_loop_binary_line_R8: assert property (@(posedge clk) disable iff (rst)
        loop_en |=> (line_tx == ($past(tx_bit) ? SYM_POS : SYM_NEG)));

    assert_fault_parks_R9: assert property (@(posedge clk) disable iff (rst)
        (cable_fault && !loop_en) |=> (rx_bit == PARK_LEVEL));

endmodule

// File: tb/mlt3_line_codec_tb.sv
`timescale 1ns/1ps
module mlt3_line_codec_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_bit = 1'b0;
    logic       enc_binary = 1'b0;
    logic       loop_en = 1'b0;
    logic       cable_fault = 1'b0;
    logic [1:0] line_rx = 2'b00;
    logic [1:0] line_tx;
    logic       rx_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mlt3_line_codec u_dut (
        .clk         (clk),
        .rst         (rst),
        .tx_bit      (tx_bit),
        .enc_binary  (enc_binary),
        .loop_en     (loop_en),
        .cable_fault (cable_fault),
        .line_rx     (line_rx),
        .line_tx     (line_tx),
        .rx_bit      (rx_bit)
    );

    // Row: {enc_binary, loop_en, cable_fault, tx_bit, line_rx[1:0], exp_tx[1:0], exp_rx}
    localparam int NROWS = 20;
    localparam logic [8:0] VEC [NROWS] = '{
        9'b000101011, // 1  R2 step to +1, R4 change 0->+1
        9'b000101000, // 2  R2 step to 0, R4 no change
        9'b000001000, // 3  R2 zero holds
        9'b000100111, // 4  R2 step to -1, R4 +1->0
        9'b000111001, // 5  R2 back to 0, R4 0->-1
        9'b000110011, // 6  R6 code 10 read as 0
        9'b000010010, // 7  R6 10 after 0 gives no change
        9'b100101011, // 8  R3 +1, R5 +1 gives 1
        9'b100011110, // 9  R3 -1, R5 -1 gives 0
        9'b100000110, // 10 R5 0 gives 0
        9'b100110010, // 11 R5/R6 code 10 gives 0
        9'b000100000, // 12 R10 MLT-3 resumes from +1 -> 0
        9'b010111011, // 13 R7 echo, R8 binary line
        9'b010001110, // 14 R7 echo 0, R8 -1
        9'b011100011, // 15 R9 loopback overrides fault
        9'b001101110, // 16 R9 parked, R2 step to -1
        9'b001111000, // 17 R9 parked, R2 step to 0
        9'b000011000, // 18 R4 -1 after -1 gives 0
        9'b000101011, // 19 R4 -1 -> +1 gives 1
        9'b110000110  // 20 R8 loopback with binary select
    };

    function automatic string row_req(input int r);
        if (r <= 7)       return "R2/R4/R6";
        else if (r <= 11) return "R3/R5";
        else if (r == 12) return "R10";
        else if (r <= 15) return "R7/R8/R9";
        else if (r <= 17) return "R9";
        else if (r <= 19) return "R4";
        else              return "R8";
    endfunction

    task automatic chk_tx(input logic [1:0] exp, input string req);
        checks++;
        if (line_tx !== exp) begin
            errors++;
            $display("FAIL %s line_tx actual=%b expected=%b", req, line_tx, exp);
        end
    endtask

    task automatic chk_rx(input logic exp, input string req);
        checks++;
        if (rx_bit !== exp) begin
            errors++;
            $display("FAIL %s rx_bit actual=%b expected=%b", req, rx_bit, exp);
        end
    endtask

    task automatic drive(input logic b, input logic l, input logic f,
                         input logic t, input logic [1:0] r);
        enc_binary  = b;
        loop_en     = l;
        cable_fault = f;
        tx_bit      = t;
        line_rx     = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_tx(2'b00, "R1 reset");
        chk_rx(1'b0, "R1 reset");
        rst = 1'b0;

        for (int i = 0; i < NROWS; i++) begin
            drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:3]);
            chk_tx(VEC[i][2:1], $sformatf("%s row %0d", row_req(i + 1), i + 1));
            chk_rx(VEC[i][0],   $sformatf("%s row %0d", row_req(i + 1), i + 1));
        end

        // R1: reset in mid-run (encoder at +1) restarts toward +1
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b01);
        chk_tx(2'b00, "R1 mid-run reset");
        chk_rx(1'b0, "R1 mid-run reset");
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        chk_tx(2'b01, "R1 first step is +1");
        chk_rx(1'b0, "R1 previous level cleared");
        // R2: full cycle
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        chk_tx(2'b00, "R2 cycle 0");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        chk_tx(2'b11, "R2 cycle -1");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        chk_tx(2'b00, "R2 cycle wraps to 0");

        // R7: line_rx ignored under loopback
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b11);
        chk_rx(1'b1, "R7 loop tx=1");
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b01);
        chk_rx(1'b0, "R7 loop tx=0 with line change");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00);
        chk_rx(1'b1, "R7 loop tx=1 with line change");
        chk_tx(2'b01, "R8 loop line +1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule